// File: doc/BRIEF.md
# Multiplexed 4:2:2 Video Input Demultiplexer with Embedded Timing Recovery

This block is the front end of a video encoder path. It takes one byte per clock of an 8-bit component video stream. The clock runs at twice the pixel rate, and the bytes arrive interleaved as Cb, Y, Cr, Y. The block splits the stream into luma and the two chroma channels. It fills in the missing chroma for every odd luma sample and delivers full 4:4:4 pixels with a one-cycle valid strobe, at most one pixel every second clock.

Line and field timing comes from the stream itself. The block watches for the timing reference word: one all-ones byte, two all-zero bytes, and then a status byte. It validates the status byte's protection bits and exposes the horizontal blanking, vertical blanking and field flags on three outputs. A reference with bad protection raises a one-cycle error pulse and leaves the flags and the active-video state untouched. Reference bytes never appear as pixels. Pixel output runs only between a start-of-line reference and the next reference.

Top module: `yc_input_stage`

## Requirements
- R1: While `rst_ni` is low, `pix_valid_o`, `trs_err_o` and all pixel buses are 0, `h_o` and `v_o` are 1 and `f_o` is 0.
- R2: The input sequence 0xFF, 0x00, 0x00, S marks a timing reference. For an accepted reference, `f_o`, `v_o` and `h_o` take bit 6, bit 5 and bit 4 of S from the cycle after S is on `vid_i`. H=0 marks start of active line and H=1 marks end of active line.
- R3: A reference is accepted only if bit 7 of S is 1 and bits 3,2,1,0 equal V^H, F^H, F^V and F^V^H. A rejected reference gives a one-cycle `trs_err_o` pulse in that same cycle. It changes neither the flags nor the active-video state, so a rejected start code produces no pixels.
- R4: `pix_valid_o` pulses only for bytes between an accepted start code and the next reference. No reference byte and no byte outside that window yields a pixel, and a line of 4N bytes yields exactly 2N pixels.
- R5: After a start code the bytes are taken as Cb, Y, Cr, Y repeating. Even pixel 2k carries the 2k-th luma byte with the k-th Cb and Cr unchanged.
- R6: Odd pixel 2k+1 carries luma byte 2k+1 and chroma (a+b+1)>>1 of chroma pairs k and k+1, per channel.
- R7: The last odd pixel of a line repeats the chroma of the final pair.
- R8: The byte phase restarts at Cb on every accepted start code, whatever number of bytes came before it.
- R9: Pixels leave in line order, never on consecutive cycles, one every two cycles within a line. The first pixel of a line is valid 10 cycles after the cycle in which the start code's status byte is on `vid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock, twice the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vid_i | input | 8 | Multiplexed component video byte |
| pix_valid_o | output | 1 | One-cycle strobe for a 4:4:4 pixel |
| pix_y_o | output | 8 | Luma of the pixel |
| pix_cb_o | output | 8 | Blue-difference chroma of the pixel |
| pix_cr_o | output | 8 | Red-difference chroma of the pixel |
| h_o | output | 1 | Horizontal blanking flag from the last accepted reference |
| v_o | output | 1 | Vertical blanking flag from the last accepted reference |
| f_o | output | 1 | Field flag from the last accepted reference |
| trs_err_o | output | 1 | Pulse for a reference whose protection bits fail |

## Verification
The hardest case to reach from the ports is the end of a line. There the final odd pixel must come out after the end code has already stopped the active window, using repeated chroma, while the four reference bytes still sitting in the delay path must be dropped. The stimulus drives complete lines with distinct chroma per pair and odd chroma sums, so that rounding shows. It closes each line with a real end code, then counts the pixels and checks the last one. A second line starts after an odd count of blanking bytes to show phase realignment. A start code with broken protection and a reset in mid-line show that no stray pixels follow.

// File: rtl/yc_in_pkg.sv
package yc_in_pkg;
  localparam int unsigned BW      = 8;
  localparam int unsigned PRE_LEN = 3;
  localparam int unsigned TAG_DLY = PRE_LEN + 1;
  localparam int unsigned FB      = BW - 2;
  localparam int unsigned VB      = BW - 3;
  localparam int unsigned HB      = BW - 4;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } tim_t;

  typedef struct packed {
    logic          act;
    logic [1:0]    ph;
    logic [BW-1:0] b;
  } tag_t;

  function automatic logic xy_ok(input logic [BW-1:0] xy);
    logic f, v, h;
    f = xy[FB];
    v = xy[VB];
    h = xy[HB];
    return xy[BW-1] && (xy[HB-1] == (v ^ h)) && (xy[HB-2] == (f ^ h)) &&
           (xy[HB-3] == (f ^ v)) && (xy[HB-4] == (f ^ v ^ h));
  endfunction

  function automatic logic [BW-1:0] avg_rnd(input logic [BW-1:0] a, input logic [BW-1:0] b);
    logic [BW:0] s;
    s = {1'b0, a} + {1'b0, b} + {{BW{1'b0}}, 1'b1};
    return s[BW:1];
  endfunction
endpackage

// File: rtl/yc_trs_detect.sv
module yc_trs_detect
  import yc_in_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] data_i,
  output logic          hit_o,
  output logic          ok_o,
  output tim_t          tim_o
);
  // hist_q[0] is the most recent byte
  logic [BW-1:0] hist_q [PRE_LEN];
  logic          pre_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PRE_LEN; i++) hist_q[i] <= '0;
    end else begin
      hist_q[0] <= data_i;
      for (int i = 1; i < PRE_LEN; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  always_comb begin
    pre_match = (hist_q[PRE_LEN-1] == {BW{1'b1}});
    for (int i = 0; i < PRE_LEN - 1; i++) pre_match = pre_match && (hist_q[i] == '0);
  end

  assign hit_o = pre_match;
  assign ok_o  = pre_match && xy_ok(data_i);
  assign tim_o = '{f: data_i[FB], v: data_i[VB], h: data_i[HB]};
endmodule

// File: rtl/yc_byte_tagger.sv
module yc_byte_tagger
  import yc_in_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] data_i,
  input  logic          hit_i,
  input  logic          sav_i,
  input  logic          eav_i,
  output tag_t          tag_o
);
  logic       act_q;
  logic [1:0] ph_q;
  tag_t       d_q [TAG_DLY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      for (int k = 0; k < TAG_DLY; k++) d_q[k] <= '0;
    end else begin
      if (sav_i)      act_q <= 1'b1;
      else if (eav_i) act_q <= 1'b0;
      ph_q  <= sav_i ? 2'd0 : ph_q + 2'd1;
      // any reference word cancels the bytes still in flight
      d_q[0] <= '{act: act_q & ~hit_i, ph: ph_q, b: data_i};
      for (int k = 1; k < TAG_DLY; k++)
        d_q[k] <= '{act: d_q[k-1].act & ~hit_i, ph: d_q[k-1].ph, b: d_q[k-1].b};
    end
  end

  assign tag_o = d_q[TAG_DLY-1];

  AST_PHASE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sav_i |=> ##1 (d_q[0].ph == 2'd0 && d_q[0].act)); // R8
endmodule

// File: rtl/yc_chroma_up.sv
module yc_chroma_up
  import yc_in_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  tag_t          tag_i,
  output logic          pix_valid_o,
  output logic [BW-1:0] pix_y_o,
  output logic [BW-1:0] pix_cb_o,
  output logic [BW-1:0] pix_cr_o
);
  localparam int unsigned NCH   = 2;
  localparam logic [1:0]  PH_CB = 2'd0;
  localparam logic [1:0]  PH_YE = 2'd1;
  localparam logic [1:0]  PH_CR = 2'd2;
  localparam logic [1:0]  PH_YO = 2'd3;

  logic          emit_even, emit_odd, pair_done;
  logic [BW-1:0] cb_nxt_q, y_nxt_q, y_even_q, y_odd_q;
  logic          pend_even_q, pend_odd_q;

  // even pixel goes out one slot late so pixels are evenly spaced
  assign emit_even = pend_even_q && (tag_i.ph == PH_CB);
  assign emit_odd  = pend_odd_q  && (tag_i.ph == PH_CR);
  assign pair_done = tag_i.act   && (tag_i.ph == PH_CR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      pix_y_o     <= '0;
      cb_nxt_q    <= '0;
      y_nxt_q     <= '0;
      y_even_q    <= '0;
      y_odd_q     <= '0;
      pend_even_q <= 1'b0;
      pend_odd_q  <= 1'b0;
    end else begin
      pix_valid_o <= emit_even | emit_odd;
      if (emit_even) begin
        pix_y_o     <= y_even_q;
        pend_even_q <= 1'b0;
      end else if (emit_odd) begin
        pix_y_o    <= y_odd_q;
        pend_odd_q <= 1'b0;
      end
      if (tag_i.act) begin
        unique case (tag_i.ph)
          PH_CB: cb_nxt_q <= tag_i.b;
          PH_YE: y_nxt_q  <= tag_i.b;
          PH_CR: begin
            y_even_q    <= y_nxt_q;
            pend_even_q <= 1'b1;
          end
          PH_YO: begin
            y_odd_q    <= tag_i.b;
            pend_odd_q <= 1'b1;
          end
        endcase
      end
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chroma
    logic [BW-1:0] cur_q, out_q, nxt, odd_c;
    // Cr of the new pair is the byte on the input right now
    assign nxt   = (ch == 0) ? cb_nxt_q : tag_i.b;
    assign odd_c = pair_done ? avg_rnd(cur_q, nxt) : cur_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cur_q <= '0;
        out_q <= '0;
      end else begin
        if (emit_even)     out_q <= cur_q;
        else if (emit_odd) out_q <= odd_c;
        if (pair_done)     cur_q <= nxt;
      end
    end

    if (ch == 0) begin : g_cb
      assign pix_cb_o = out_q;
    end else begin : g_cr
      assign pix_cr_o = out_q;
    end
  end

  AST_PIX_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |=> !pix_valid_o); // R9
endmodule

// File: rtl/yc_input_stage.sv
module yc_input_stage
  import yc_in_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] vid_i,
  output logic          pix_valid_o,
  output logic [BW-1:0] pix_y_o,
  output logic [BW-1:0] pix_cb_o,
  output logic [BW-1:0] pix_cr_o,
  output logic          h_o,
  output logic          v_o,
  output logic          f_o,
  output logic          trs_err_o
);
  logic hit, ok, sav, eav;
  tim_t tim;
  tag_t tag;

  yc_trs_detect u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (vid_i),
    .hit_o  (hit),
    .ok_o   (ok),
    .tim_o  (tim)
  );

  assign sav = ok & ~tim.h;
  assign eav = ok &  tim.h;

  yc_byte_tagger u_tagger (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (vid_i),
    .hit_i  (hit),
    .sav_i  (sav),
    .eav_i  (eav),
    .tag_o  (tag)
  );

  yc_chroma_up u_up (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tag_i       (tag),
    .pix_valid_o (pix_valid_o),
    .pix_y_o     (pix_y_o),
    .pix_cb_o    (pix_cb_o),
    .pix_cr_o    (pix_cr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_o       <= 1'b1;
      v_o       <= 1'b1;
      f_o       <= 1'b0;
      trs_err_o <= 1'b0;
    end else begin
      trs_err_o <= hit & ~ok;
      if (ok) begin
        h_o <= tim.h;
        v_o <= tim.v;
        f_o <= tim.f;
      end
    end
  end

  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trs_err_o |=> !trs_err_o); // R3
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trs_err_o |-> $stable({h_o, v_o, f_o})); // R3
endmodule

// File: tb/yc_input_stage_test.sv
`timescale 1ns/1ps
module yc_input_stage_test;
  import yc_in_pkg::*;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [BW-1:0] vid_i = '0;
  logic          pix_valid_o, h_o, v_o, f_o, trs_err_o;
  logic [BW-1:0] pix_y_o, pix_cb_o, pix_cr_o;

  always #2.5 clk = ~clk;

  yc_input_stage uut (
    .clk_i(clk), .rst_ni(rst_ni), .vid_i(vid_i),
    .pix_valid_o(pix_valid_o), .pix_y_o(pix_y_o), .pix_cb_o(pix_cb_o), .pix_cr_o(pix_cr_o),
    .h_o(h_o), .v_o(v_o), .f_o(f_o), .trs_err_o(trs_err_o)
  );

  // {status byte, err, f, v, h} expected after each reference
  localparam int NVEC = 11;
  localparam logic [11:0] VEC [NVEC] = '{
    {8'hAB, 4'b0010}, {8'hB6, 4'b0011}, {8'h81, 4'b1011}, {8'h80, 4'b0000},
    {8'h9D, 4'b0001}, {8'hDA, 4'b0101}, {8'hC7, 4'b0100}, {8'h1D, 4'b1100},
    {8'hEC, 4'b0110}, {8'hF1, 4'b0111}, {8'hF0, 4'b1111}
  };

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int got_y[64], got_cb[64], got_cr[64], got_t[64];
  int ngot = 0;
  always @(negedge clk) begin
    if (pix_valid_o && ngot < 64) begin
      got_y[ngot]  = int'(pix_y_o);
      got_cb[ngot] = int'(pix_cb_o);
      got_cr[ngot] = int'(pix_cr_o);
      got_t[ngot]  = cyc;
      ngot = ngot + 1;
    end
  end

  int nchk = 0, nfail = 0, code_cyc = 0;
  int lcb[4], lcr[4], ly[8];
  int nq = 0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int b);
    vid_i = b[BW-1:0];
    @(negedge clk);
  endtask

  task automatic send_code(input int xy);
    send(255); send(0); send(0);
    code_cyc = cyc;
    send(xy);
  endtask

  task automatic send_line();
    for (int q = 0; q < nq; q++) begin
      send(lcb[q]); send(ly[2*q]); send(lcr[q]); send(ly[2*q+1]);
    end
  endtask

  task automatic check_line(input int base, input int k0);
    int cnt;
    cnt = ngot - base;
    chk("R4 pixel count", cnt, 2 * nq);
    if (cnt > 0) chk("R9 first pixel latency", got_t[base] - k0, 10);
    for (int n = 0; n < 2 * nq && n < cnt; n++) begin
      int q, ecb, ecr;
      q = n / 2;
      chk("R5 luma order", got_y[base+n], ly[n]);
      if (n > 0) chk("R9 pixel spacing", got_t[base+n] - got_t[base+n-1], 2);
      if (n % 2 == 0) begin
        chk("R5 co-sited cb", got_cb[base+n], lcb[q]);
        chk("R5 co-sited cr", got_cr[base+n], lcr[q]);
      end else if (q + 1 < nq) begin
        ecb = (lcb[q] + lcb[q+1] + 1) / 2;
        ecr = (lcr[q] + lcr[q+1] + 1) / 2;
        chk("R6 interpolated cb", got_cb[base+n], ecb);
        chk("R6 interpolated cr", got_cr[base+n], ecr);
      end else begin
        chk("R7 repeated cb", got_cb[base+n], lcb[q]);
        chk("R7 repeated cr", got_cr[base+n], lcr[q]);
      end
    end
  endtask

  task automatic check_reset_state();
    chk("R1 valid", int'(pix_valid_o), 0);
    chk("R1 y", int'(pix_y_o), 0);
    chk("R1 cb", int'(pix_cb_o), 0);
    chk("R1 cr", int'(pix_cr_o), 0);
    chk("R1 h", int'(h_o), 1);
    chk("R1 v", int'(v_o), 1);
    chk("R1 f", int'(f_o), 0);
    chk("R1 err", int'(trs_err_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R9 watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int base, k0, fsave;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_ni = 1'b1;
    repeat (4) send(16);

    // reference decoding table
    for (int i = 0; i < NVEC; i++) begin
      send_code(int'(VEC[i][11:4]));
      chk("R3 error pulse", int'(trs_err_o), int'(VEC[i][3]));
      chk("R2 f flag", int'(f_o), int'(VEC[i][2]));
      chk("R2 v flag", int'(v_o), int'(VEC[i][1]));
      chk("R2 h flag", int'(h_o), int'(VEC[i][0]));
      send(16);
      chk("R3 error one cycle", int'(trs_err_o), 0);
      repeat (6) send(16);
    end
    repeat (12) send(16);

    // line 1: four pairs, odd sums to expose rounding
    lcb = '{20, 31, 50, 90};
    lcr = '{200, 101, 100, 60};
    for (int n = 0; n < 8; n++) ly[n] = 30 + 10 * n;
    nq = 4;
    base = ngot;
    send_code(8'h80);
    k0 = code_cyc;
    send_line();
    send_code(8'h9D);
    repeat (12) send(16);
    check_line(base, k0);

    // line 2 after an odd count of blanking bytes
    repeat (7) send(128);
    lcb = '{100, 110, 0, 0};
    lcr = '{120, 130, 0, 0};
    ly  = '{60, 61, 62, 63, 0, 0, 0, 0};
    nq = 2;
    base = ngot;
    send_code(8'h80);
    k0 = code_cyc;
    send_line();
    send_code(8'h9D);
    repeat (12) send(16);
    check_line(base, k0);   // R8 phase realigned

    // start code with broken protection
    fsave = {int'(f_o), int'(v_o), int'(h_o)};
    base = ngot;
    send_code(8'h00);
    chk("R3 bad start flagged", int'(trs_err_o), 1);
    repeat (8) send(85);
    chk("R3 flags kept", {int'(f_o), int'(v_o), int'(h_o)}, fsave);
    chk("R3 no pixels from bad start", ngot - base, 0);

    // reset in the middle of a line
    send_code(8'h80);
    send(40); send(50); send(60); send(70);
    rst_ni = 1'b0;
    #1;
    check_reset_state();
    @(negedge clk);
    rst_ni = 1'b1;
    base = ngot;
    repeat (20) send(96);
    chk("R4 no pixels without start code", ngot - base, 0);
    chk("R4 valid low after reset", int'(pix_valid_o), 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule